// File: doc/BRIEF.md
# Shadow Stack Pointer Register

This block holds the pointer to the top of a shadow stack, meaning the address of the element most recently pushed, and decides whether a given access to it is allowed. A requester presents a register access with an address, a write-enable, write data and the hart context: the current privilege mode, whether the current register width is 32 or 64 bits, and three shadow-stack enable bits. The enables come from the machine, hypervisor and supervisor environment-configuration levels.

An access to the matching address is checked against the enable chain. A refused access raises exactly one of two fault flags, illegal-instruction or virtual-instruction, and is otherwise inert. An allowed access returns the stored pointer with its alignment bits forced to zero and, for a write, replaces the pointer. Read data and fault flags are registered and appear in the cycle after the request. Decoding of shadow stack push and pop instructions, and the updates they make, happen outside this block.

Top module: `sstk_ptr_csr`

## Requirements
- R1: Only a request with `req_valid`=1 and `req_addr` equal to `CSR_ADDR` (default 12'h011) is acted on. Any other request raises no fault, returns zero read data and leaves the stored pointer unchanged.
- R2: `priv_mode` encodes U=0, S=1, M=3, VU=4, VS=5. An access in M (3) never faults, whatever the enable bits are. Codes 2, 6 and 7 count as below M and are subject only to the machine-level check.
- R3: An access in any mode other than M while `en_mach`=0 raises `fault_illegal`.
- R4: Otherwise, an access in U while `en_super`=0 raises `fault_illegal`.
- R5: Otherwise, an access in VS while `en_hyp`=0 raises `fault_virtual`.
- R6: Otherwise, an access in VU while `en_hyp`=0 or `en_super`=0 raises `fault_virtual`.
- R7: The two fault flags are never high together, and illegal-instruction wins when both would apply. Both flags and `rd_data` are registered: they reflect the request of the previous cycle and return to zero after an idle cycle.
- R8: A faulting write leaves the stored pointer unchanged, and a faulting access returns zero read data.
- R9: Read data always has bits 1:0 at zero. With `xlen_is_64`=1, bit 2 also reads as zero. With `xlen_is_64`=0, bits 63:32 read as zero and bit 2 shows the stored bit.
- R10: An allowed write takes effect at the clock edge that samples it, and a read made in the same request returns the old value. A write with `xlen_is_64`=0 stores the low 32 bits of the data, zero-extended.
- R11: Reset (`rst_n`=0) clears the stored pointer, both fault flags and `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Register access request this cycle |
| req_addr | input | ADDR_W (12) | Register address of the request |
| req_wen | input | 1 | Request is a read-write (1) or read-only (0) access |
| req_wdata | input | MAX_XLEN (64) | Write data |
| priv_mode | input | 3 | Current privilege mode code |
| xlen_is_64 | input | 1 | Current register width is 64 (1) or 32 (0) |
| en_mach | input | 1 | Machine-level shadow stack enable |
| en_hyp | input | 1 | Hypervisor-level shadow stack enable |
| en_super | input | 1 | Supervisor-level shadow stack enable |
| rd_data | output | MAX_XLEN (64) | Masked read data for the previous request |
| fault_illegal | output | 1 | Previous request raised illegal-instruction |
| fault_virtual | output | 1 | Previous request raised virtual-instruction |

## Verification
The bench builds the block with its default parameters: a 64-bit maximum width, a 12-bit address and the pointer at 12'h011. Because the width is a run-time input, this one build reaches both masking shapes, including pointers written at one width and read back at the other. It also reaches every combination of mode code and enable bits, the undefined mode codes among them. Near-miss addresses such as 12'h010 and 12'h111 exercise the address match.

// File: rtl/ssp_pkg.sv
// Shared types for the shadow stack pointer register.
// Assumes a 3-bit privilege mode code driven by the hart context.
package ssp_pkg;

    // Privilege mode encoding seen on the priv_mode port.
    typedef enum logic [2:0] {
        PRIV_U  = 3'd0,
        PRIV_S  = 3'd1,
        PRIV_M  = 3'd3,
        PRIV_VU = 3'd4,
        PRIV_VS = 3'd5
    } priv_e;

    // Outcome of the permission check for one access.
    typedef enum logic [1:0] {
        ACC_OK      = 2'd0,
        ACC_ILLEGAL = 2'd1,
        ACC_VIRTUAL = 2'd2
    } acc_e;

endpackage

// File: rtl/ssp_access_gate.sv
// Permission check for a shadow stack pointer access.
// Walks the enable chain and yields one verdict, with illegal-instruction
// taking precedence over virtual-instruction. Purely combinational.
// Assumes any mode code other than M counts as below M.
module ssp_access_gate
    import ssp_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       en_mach,
    input  logic       en_hyp,
    input  logic       en_super,
    output acc_e       verdict
);

    logic below_m;
    logic ill_mach;
    logic ill_user;
    logic virt_vs;
    logic virt_vu;

    // Decode each refusal condition separately.
    always_comb begin
        below_m  = (mode != PRIV_M);
        ill_mach = below_m && !en_mach;
        ill_user = (mode == PRIV_U) && !en_super;
        virt_vs  = (mode == PRIV_VS) && !en_hyp;
        virt_vu  = (mode == PRIV_VU) && (!en_hyp || !en_super);
    end

    // Prioritise: illegal first, then virtual, else allowed.
    always_comb begin
        if (ill_mach || ill_user) begin
            verdict = ACC_ILLEGAL;
        end else if (virt_vs || virt_vu) begin
            verdict = ACC_VIRTUAL;
        end else begin
            verdict = ACC_OK;
        end
    end

endmodule

// File: rtl/ssp_ptr_store.sv
// Storage for the shadow stack pointer.
// Keeps only bits above the 4-byte alignment; bits 1:0 are never stored.
// A 32-bit-wide write stores its low half zero-extended.
// Assumes MAX_XLEN is 32 or 64.
module ssp_ptr_store #(
    parameter int MAX_XLEN = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  xlen_is_64,
    input  logic [MAX_XLEN-1:2]   wdata,
    output logic [MAX_XLEN-1:2]   ptr
);

    localparam int NARROW = 32;

    logic [MAX_XLEN-1:2] wval;

    // Shape the incoming value for the current register width.
    generate
        if (MAX_XLEN > NARROW) begin : g_wide
            always_comb begin
                if (xlen_is_64) begin
                    wval = wdata;
                end else begin
                    wval = {{(MAX_XLEN-NARROW){1'b0}}, wdata[NARROW-1:2]};
                end
            end
        end else begin : g_narrow
            logic unused_width;
            assign unused_width = xlen_is_64;
            always_comb wval = wdata;
        end
    endgenerate

    // Hold the pointer; clear on reset, load on an allowed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_en) begin
            ptr <= wval;
        end
    end

endmodule

// File: rtl/ssp_read_mask.sv
// Read view of the stored pointer for the current register width.
// Bits 1:0 read zero always; bit 2 reads zero in 64-bit width;
// bits at and above 32 read zero in 32-bit width.
module ssp_read_mask #(
    parameter int MAX_XLEN = 64
) (
    input  logic [MAX_XLEN-1:2] ptr,
    input  logic                xlen_is_64,
    output logic [MAX_XLEN-1:0] view
);

    localparam int NARROW = 32;

    // Per-bit masking selected by bit position.
    generate
        for (genvar i = 0; i < MAX_XLEN; i++) begin : g_bit
            if (i < 2) begin : g_zero
                assign view[i] = 1'b0;
            end else if (i == 2) begin : g_b2
                assign view[i] = ptr[i] & ~xlen_is_64;
            end else if (i < NARROW) begin : g_low
                assign view[i] = ptr[i];
            end else begin : g_high
                assign view[i] = ptr[i] & xlen_is_64;
            end
        end
    endgenerate

endmodule

// File: rtl/sstk_ptr_csr.sv
// Shadow stack pointer register with access checking.
// Matches one register address, checks the enable chain for the current
// mode, updates the pointer on an allowed write and returns the masked
// pointer with the fault verdict one cycle after the request.
// Assumes at most one request per cycle and a synchronous active-low reset.
module sstk_ptr_csr
    import ssp_pkg::*;
#(
    parameter int          MAX_XLEN = 64,
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] CSR_ADDR = 12'h011
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_wen,
    input  logic [MAX_XLEN-1:0]  req_wdata,
    input  logic [2:0]           priv_mode,
    input  logic                 xlen_is_64,
    input  logic                 en_mach,
    input  logic                 en_hyp,
    input  logic                 en_super,
    output logic [MAX_XLEN-1:0]  rd_data,
    output logic                 fault_illegal,
    output logic                 fault_virtual
);

    localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(CSR_ADDR);

    acc_e                verdict;
    logic                hit;
    logic                allowed;
    logic                wr_go;
    logic [MAX_XLEN-1:2] ptr;
    logic [MAX_XLEN-1:0] view;
    logic [1:0]          unused_wlow;

    assign unused_wlow = req_wdata[1:0];

    // Address match and permission outcome for this request.
    always_comb begin
        hit     = req_valid && (req_addr == MATCH);
        allowed = hit && (verdict == ACC_OK);
        wr_go   = allowed && req_wen;
    end

    ssp_access_gate u_gate (
        .mode     (priv_mode),
        .en_mach  (en_mach),
        .en_hyp   (en_hyp),
        .en_super (en_super),
        .verdict  (verdict)
    );

    ssp_ptr_store #(.MAX_XLEN(MAX_XLEN)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_go),
        .xlen_is_64 (xlen_is_64),
        .wdata      (req_wdata[MAX_XLEN-1:2]),
        .ptr        (ptr)
    );

    ssp_read_mask #(.MAX_XLEN(MAX_XLEN)) u_mask (
        .ptr        (ptr),
        .xlen_is_64 (xlen_is_64),
        .view       (view)
    );

    // Register the response: old pointer view or zero, plus fault flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data       <= '0;
            fault_illegal <= 1'b0;
            fault_virtual <= 1'b0;
        end else begin
            rd_data       <= allowed ? view : '0;
            fault_illegal <= hit && (verdict == ACC_ILLEGAL);
            fault_virtual <= hit && (verdict == ACC_VIRTUAL);
        end
    end

endmodule

// File: rtl/ssp_csr_checker.sv
// Temporal checks on the shadow stack pointer register ports.
// Bound to every instance of sstk_ptr_csr.
module ssp_csr_checker #(
    parameter int          MAX_XLEN = 64,
    parameter int          ADDR_W   = 12,
    parameter logic [11:0] CSR_ADDR = 12'h011
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [ADDR_W-1:0]   req_addr,
    input logic [2:0]          priv_mode,
    input logic                xlen_is_64,
    input logic                en_mach,
    input logic [MAX_XLEN-1:0] rd_data,
    input logic                fault_illegal,
    input logic                fault_virtual
);

    logic req_hit;
    assign req_hit = req_valid && (req_addr == ADDR_W'(CSR_ADDR));

    // R1: a request to another address never faults
    p_miss_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_hit |=> (!fault_illegal && !fault_virtual && rd_data == '0));

    // R2: machine mode always allowed
    p_mach_allowed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && priv_mode == 3'd3) |=> (!fault_illegal && !fault_virtual));

    // R3: below M with machine enable clear is illegal
    p_mach_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && priv_mode != 3'd3 && !en_mach) |=> fault_illegal);

    // R7: faults are exclusive
    p_fault_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_illegal && fault_virtual));

    // R8: a faulting access returns zero
    p_fault_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_illegal || fault_virtual) |-> rd_data == '0);

    // R9: alignment bits always read zero
    p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[1:0] == 2'b00);

    // R9: wide reads also clear bit 2
    p_bit2_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && xlen_is_64) |=> rd_data[2] == 1'b0);

    // R9: narrow reads clear the upper half
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_hit && !xlen_is_64) |=> rd_data[MAX_XLEN-1:32] == '0);

endmodule

bind sstk_ptr_csr ssp_csr_checker #(
    .MAX_XLEN (MAX_XLEN),
    .ADDR_W   (ADDR_W),
    .CSR_ADDR (CSR_ADDR)
) u_ssp_chk (.*);

// File: tb/sstk_ptr_csr_test.sv
`timescale 1ns/1ps
module sstk_ptr_csr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [11:0] req_addr = '0;
    logic        req_wen = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [2:0]  priv_mode = 3'd3;
    logic        xlen_is_64 = 1'b1;
    logic        en_mach = 1'b0;
    logic        en_hyp = 1'b0;
    logic        en_super = 1'b0;
    logic [63:0] rd_data;
    logic        fault_illegal;
    logic        fault_virtual;

    int checks = 0;
    int failures = 0;
    logic [63:0] mreg = '0;

    always #10 clk = ~clk;

    sstk_ptr_csr uut (.*);

    task automatic compare(input logic [63:0] erd, input bit eill, input bit evir, input string tag);
        checks++;
        if (rd_data !== erd || fault_illegal !== eill || fault_virtual !== evir) begin
            failures++;
            $display("FAIL %s: rd=%h ill=%b vir=%b expected rd=%h ill=%b vir=%b",
                     tag, rd_data, fault_illegal, fault_virtual, erd, eill, evir);
        end
    endtask

    // One request per cycle: drive, predict, clock, compare.
    task automatic step(input bit v, input logic [11:0] a, input bit we, input logic [63:0] wd,
                        input logic [2:0] m, input bit x64, input bit me, input bit he,
                        input bit se, input string tag);
        bit hit, ill, vir;
        logic [63:0] erd;
        logic [63:0] nreg;
        req_valid = v; req_addr = a; req_wen = we; req_wdata = wd;
        priv_mode = m; xlen_is_64 = x64; en_mach = me; en_hyp = he; en_super = se;
        hit = v && (a == 12'h011);
        ill = hit && ((m != 3'd3 && !me) || (m == 3'd0 && !se));
        vir = hit && !ill && ((m == 3'd5 && !he) || (m == 3'd4 && (!he || !se)));
        erd = '0;
        nreg = mreg;
        if (hit && !ill && !vir) begin
            erd = x64 ? (mreg & ~64'h7) : {32'h0, mreg[31:0] & ~32'h3};
            if (we) nreg = x64 ? (wd & ~64'h3) : {32'h0, wd[31:0] & ~32'h3};
        end
        @(posedge clk);
        mreg = nreg;
        @(negedge clk);
        compare(erd, ill, vir, tag);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog: run did not complete, expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare('0, 0, 0, "R11 reset outputs");
        rst_n = 1'b1;
        // R11: pointer reads zero after reset
        step(1, 12'h011, 0, 0, 3'd3, 1, 0, 0, 0, "R11 reset pointer");
        // R10: write in M, read-in-same-request returns old value
        step(1, 12'h011, 1, 64'hDEAD_BEEF_1234_567F, 3'd3, 1, 0, 0, 0, "R10 write returns old");
        step(1, 12'h011, 0, 0, 3'd3, 1, 0, 0, 0, "R9 wide read masks bit2");
        step(1, 12'h011, 0, 0, 3'd3, 0, 0, 0, 0, "R9 narrow read keeps bit2");
        step(0, 12'h011, 0, 0, 3'd3, 1, 1, 1, 1, "R7 idle clears outputs");
        // R1: near-miss addresses
        step(1, 12'h010, 1, 64'h1111, 3'd0, 1, 0, 0, 0, "R1 miss 0x010");
        step(1, 12'h111, 1, 64'h2222, 3'd3, 1, 1, 1, 1, "R1 miss 0x111");
        step(1, 12'h011, 0, 0, 3'd3, 1, 0, 0, 0, "R1 pointer untouched");
        // R3/R4/R5/R6 fault cases
        step(1, 12'h011, 1, 64'h5, 3'd1, 1, 0, 1, 1, "R3 S without machine enable");
        step(1, 12'h011, 1, 64'h5, 3'd5, 1, 0, 0, 0, "R3 VS without machine enable wins");
        step(1, 12'h011, 1, 64'h5, 3'd0, 1, 1, 1, 0, "R4 U without supervisor enable");
        step(1, 12'h011, 1, 64'h5, 3'd5, 1, 1, 0, 1, "R5 VS without hypervisor enable");
        step(1, 12'h011, 1, 64'h5, 3'd4, 1, 1, 1, 0, "R6 VU without supervisor enable");
        step(1, 12'h011, 1, 64'h5, 3'd4, 1, 1, 0, 1, "R6 VU without hypervisor enable");
        step(1, 12'h011, 0, 0, 3'd3, 1, 0, 0, 0, "R8 faulting writes ignored");
        // R2: undefined code treated as below M
        step(1, 12'h011, 0, 0, 3'd7, 1, 0, 1, 1, "R2 undefined code gated");
        step(1, 12'h011, 0, 0, 3'd6, 1, 1, 0, 0, "R2 undefined code allowed");
        // R10: narrow write zero-extends
        step(1, 12'h011, 1, 64'hFFFF_FFFF_8765_4326, 3'd0, 0, 1, 0, 1, "R10 narrow write");
        step(1, 12'h011, 0, 0, 3'd4, 1, 1, 1, 1, "R10 narrow write readback");
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic [11:0] a;
            r = $urandom;
            a = (r[3:0] == 4'd0) ? 12'($urandom) : 12'h011;
            step(r[4], a, r[5], {$urandom, $urandom}, r[8:6], r[9], r[10] | r[13],
                 r[11] | r[14], r[12] | r[15], "R7 random request");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule